// File: doc/BRIEF.md
# Variable-latency static memory controller

This block turns single internal read and write requests into accesses on an external asynchronous memory bus. The bus carries chip selects, an output-enable strobe, two write strobes, four byte-select lines, address and data. Every access has three phases: a programmed setup, a strobe of programmed minimum width, and a programmed hold. On chip selects marked as variable-latency, a device ready input stretches the strobe by as many cycles as the device needs. A timeout stops a device that never becomes ready.

Each chip select has its own configuration bits. One sets a 16-bit or 32-bit data path. The other marks the device as variable-latency, which changes the write strobe it uses and makes the controller honour ready. On a 16-bit path a word request runs as two halfword accesses. The read data is gathered into a single response. By default reads are issued as full words. A global mode bit makes reads carry their true size for devices that react to access width.

Top module: `stmem_ctrl`

## Requirements
- R1: After reset all chip selects, strobes and byte selects are high (inactive), the data bus is not driven, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: The chip select is chosen by address bit `CS_LSB` (default 12); address 0x0000 selects chip select 0. Exactly one chip select is low for the whole access.
- R3: A read drives `mem_oe_no` low during the strobe phase, with neither write strobe low and the data bus not driven.
- R4: A write drives `mem_pwe_no` low when `cfg_var_i` is 1 for the chip select, and drives `mem_we_no` low otherwise. The write data is driven throughout.
- R5: Each access has `SETUP_CYC` cycles with the chip select low before the strobe falls, and `HOLD_CYC` cycles after the strobe rises before the chip select rises.
- R6: On a variable-latency chip select the strobe lasts at least `STROBE_CYC` cycles and ends only after ready, taken through a two-flop synchroniser, reads 1. On other chip selects ready is ignored and the strobe lasts exactly `STROBE_CYC` cycles.
- R7: When `cfg_exact_rd_i` is 0, every read is a full word. On a 32-bit path the address bits [1:0] are 0 and all four byte selects are low. On a 16-bit path the read is two halfword accesses with byte selects 4'b1100.
- R8: When `cfg_exact_rd_i` is 1, reads carry their size (`req_size_i`: 0 byte, 1 halfword, 2 word). A byte read drives its full address and one active select. A halfword read drives address bit 0 low with selects 4'b1100 (lanes 0–1) or 4'b0011 (lanes 2–3). On a 16-bit path a byte read uses select bit 0 for even addresses and bit 1 for odd addresses.
- R9: On a 16-bit path (`cfg_bus16_i` bit 1) a word access is split into two halfword accesses on `mem_dq_*[15:0]`, at address bits [1:0] = 00 and then 10. Read data from the lower access goes to `rsp_rdata_o[15:0]` and from the upper access to `[31:16]`. A single-halfword access returns only its own half, and the other half is 0.
- R10: Write byte selects are the inverted `req_be_i` lanes (bit n = byte lane n) on a 32-bit path. On a 16-bit path they are `{2'b11, ~be[2h+1:2h]}` for half h, with address bits [1:0] = 00 on a 32-bit path.
- R11: If ready stays 0 for `TMO_CYC` wait cycles past the minimum strobe, the access ends with `rsp_err_o` set, and no second half is issued.
- R12: Completion is a one-cycle `rsp_valid_o` pulse carrying `rsp_rdata_o` (0 for writes) and `rsp_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_bus16_i | input | NUM_CS | Per chip select: 1 selects a 16-bit data path |
| cfg_var_i | input | NUM_CS | Per chip select: 1 marks a variable-latency device |
| cfg_exact_rd_i | input | 1 | 1 issues reads at their true size |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle |
| req_we_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | AW | Byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_be_i | input | 4 | Write byte enables by lane |
| req_wdata_i | input | 32 | Write data, lane aligned |
| rsp_valid_o | output | 1 | Access complete pulse |
| rsp_rdata_o | output | 32 | Read data, lane aligned |
| rsp_err_o | output | 1 | Access ended by timeout |
| mem_cs_no | output | NUM_CS | Chip selects, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write strobe for fixed-timing devices, active low |
| mem_pwe_no | output | 1 | Write strobe for variable-latency devices, active low |
| mem_bs_no | output | 4 | Byte selects, active low |
| mem_addr_o | output | AW | External address |
| mem_dq_o | output | 32 | Write data out |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 32 | Read data in |
| mem_rdy_i | input | 1 | Device ready, asynchronous |

## Verification
A wrong phase counter shows up at the bus within one access. The setup or hold span, or the strobe width, comes out off by some cycles, and the bench measures each of these at every strobe edge. A wrong half index or lane mapping shows on the first strobe as a wrong address bit or byte-select pattern. A bad assembly register shows in the response that follows. A wait counter or synchroniser fault shows as a strobe that is too short or too long on the ready-stretched accesses, or as a missing or spurious error flag at the end of a timed-out access, after about 260 cycles.

// File: rtl/stmem_pkg.sv
package stmem_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } bus_phase_e;
endpackage

// File: rtl/stmem_sync.sv
module stmem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/stmem_lane_map.sv
module stmem_lane_map
  import stmem_pkg::*;
(
  input  logic        bus16_i,
  input  logic        we_i,
  input  logic        exact_i,
  input  xfer_size_e  size_i,
  input  logic [1:0]  alo_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  input  logic        half_i,
  output logic [1:0]  alo_o,
  output logic [3:0]  bs_no,
  output logic [31:0] dq_o
);
  always_comb begin
    alo_o = 2'b00;
    bs_no = 4'b0000;
    dq_o  = wdata_i;
    if (!bus16_i) begin
      if (we_i) begin
        bs_no = ~be_i;
      end else if (exact_i) begin
        case (size_i)
          SZ_BYTE: begin
            alo_o = alo_i;
            bs_no = ~(4'b0001 << alo_i);
          end
          SZ_HALF: begin
            alo_o = {alo_i[1], 1'b0};
            bs_no = alo_i[1] ? 4'b0011 : 4'b1100;
          end
          default: ;
        endcase
      end
    end else begin
      alo_o = {half_i, 1'b0};
      dq_o  = {16'h0000, half_i ? wdata_i[31:16] : wdata_i[15:0]};
      if (we_i) begin
        bs_no = {2'b11, ~(half_i ? be_i[3:2] : be_i[1:0])};
      end else begin
        bs_no = 4'b1100;
        if (exact_i && size_i == SZ_BYTE) begin
          alo_o = {half_i, alo_i[0]};
          bs_no = {2'b11, alo_i[0] ? 2'b01 : 2'b10};
        end
      end
    end
  end
endmodule

// File: rtl/stmem_seq.sv
module stmem_seq
  import stmem_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int TMO_CYC    = 255
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       two_phase_i,
  input  logic       use_rdy_i,
  input  logic       rdy_i,
  output bus_phase_e phase_o,
  output logic       part_o,
  output logic       capture_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int TMAX = (SETUP_CYC > STROBE_CYC)
                      ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                      : ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int TW = $clog2(TMAX + 1);
  localparam int WW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] SETUP_LAST  = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] STROBE_LAST = TW'(STROBE_CYC - 1);
  localparam logic [TW-1:0] HOLD_LAST   = TW'(HOLD_CYC - 1);
  localparam logic [WW-1:0] WAIT_LAST   = WW'(TMO_CYC);

  bus_phase_e    ph_q;
  logic [TW-1:0] cnt_q;
  logic [WW-1:0] wcnt_q;
  logic          part_q, done_q, err_q;
  logic          min_met, go_on, tmo_hit;

  assign min_met = (ph_q == PH_STROBE) && (cnt_q == STROBE_LAST);
  assign go_on   = !use_rdy_i || rdy_i;
  assign tmo_hit = (wcnt_q == WAIT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wcnt_q <= '0;
      part_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_SETUP;
          cnt_q  <= '0;
          wcnt_q <= '0;
          part_q <= 1'b0;
          err_q  <= 1'b0;
        end
        PH_SETUP: begin
          if (cnt_q == SETUP_LAST) begin
            ph_q  <= PH_STROBE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_STROBE: begin
          if (!min_met) cnt_q <= cnt_q + 1'b1;
          else if (go_on) begin
            ph_q  <= PH_HOLD;
            cnt_q <= '0;
          end else if (tmo_hit) begin
            err_q <= 1'b1;
            ph_q  <= PH_HOLD;
            cnt_q <= '0;
          end else wcnt_q <= wcnt_q + 1'b1;
        end
        default: begin
          if (cnt_q == HOLD_LAST) begin
            cnt_q <= '0;
            if (two_phase_i && !part_q && !err_q) begin
              ph_q   <= PH_SETUP;
              part_q <= 1'b1;
              wcnt_q <= '0;
            end else begin
              ph_q   <= PH_IDLE;
              done_q <= 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign phase_o   = ph_q;
  assign part_o    = part_q;
  assign capture_o = min_met && (go_on || tmo_hit);
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/stmem_ctrl.sv
module stmem_ctrl
  import stmem_pkg::*;
#(
  parameter int NUM_CS      = 2,
  parameter int AW          = 16,
  parameter int CS_LSB      = 12,
  parameter int SETUP_CYC   = 1,
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1,
  parameter int TMO_CYC     = 255,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CS-1:0] cfg_bus16_i,
  input  logic [NUM_CS-1:0] cfg_var_i,
  input  logic              cfg_exact_rd_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [3:0]        req_be_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_err_o,
  output logic [NUM_CS-1:0] mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_pwe_no,
  output logic [3:0]        mem_bs_no,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [31:0]       mem_dq_i,
  input  logic              mem_rdy_i
);
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  bus_phase_e  phase;
  logic        part, capture, done, err, rdy_s;
  logic        accept, active, strobe;
  logic        r_we;
  logic [AW-1:0] r_addr;
  xfer_size_e  r_size;
  logic [3:0]  r_be;
  logic [31:0] r_wdata, rdata_q;
  logic [CSW-1:0] r_cs;
  logic [NUM_CS-1:0] cs_hit;
  logic        bus16, vdev, two_phase, half;
  logic [1:0]  alo;
  logic [3:0]  bs_n;
  logic [31:0] dq;

  assign req_ready_o = (phase == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_we    <= 1'b0;
      r_addr  <= '0;
      r_size  <= SZ_WORD;
      r_be    <= '0;
      r_wdata <= '0;
      r_cs    <= '0;
    end else if (accept) begin
      r_we    <= req_we_i;
      r_addr  <= req_addr_i;
      r_size  <= xfer_size_e'(req_size_i);
      r_be    <= req_be_i;
      r_wdata <= req_wdata_i;
      r_cs    <= req_addr_i[CS_LSB +: CSW];
    end
  end

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_hit[i] = (r_cs == CSW'(i));
    end
  endgenerate

  assign bus16 = |(cs_hit & cfg_bus16_i);
  assign vdev  = |(cs_hit & cfg_var_i);

  // 16-bit path: word writes and non-exact or word reads take two halves
  assign two_phase = bus16 && (r_we ? (r_size == SZ_WORD)
                                    : (!cfg_exact_rd_i || r_size == SZ_WORD));
  assign half      = two_phase ? part : r_addr[1];

  stmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mem_rdy_i),
    .q_o    (rdy_s)
  );

  stmem_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .TMO_CYC    (TMO_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .two_phase_i (two_phase),
    .use_rdy_i   (vdev),
    .rdy_i       (rdy_s),
    .phase_o     (phase),
    .part_o      (part),
    .capture_o   (capture),
    .done_o      (done),
    .err_o       (err)
  );

  stmem_lane_map u_lanes (
    .bus16_i (bus16),
    .we_i    (r_we),
    .exact_i (cfg_exact_rd_i),
    .size_i  (r_size),
    .alo_i   (r_addr[1:0]),
    .be_i    (r_be),
    .wdata_i (r_wdata),
    .half_i  (half),
    .alo_o   (alo),
    .bs_no   (bs_n),
    .dq_o    (dq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (accept) rdata_q <= '0;
    else if (capture && !r_we) begin
      if (!bus16)    rdata_q         <= mem_dq_i;
      else if (half) rdata_q[31:16]  <= mem_dq_i[15:0];
      else           rdata_q[15:0]   <= mem_dq_i[15:0];
    end
  end

  assign active      = (phase != PH_IDLE);
  assign strobe      = (phase == PH_STROBE);
  assign mem_cs_no   = ~(cs_hit & {NUM_CS{active}});
  assign mem_oe_no   = ~(strobe && !r_we);
  assign mem_pwe_no  = ~(strobe && r_we && vdev);
  assign mem_we_no   = ~(strobe && r_we && !vdev);
  assign mem_bs_no   = active ? bs_n : 4'hF;
  assign mem_addr_o  = {r_addr[AW-1:2], alo};
  assign mem_dq_o    = dq;
  assign mem_dq_oe_o = active && r_we;

  assign rsp_valid_o = done;
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = done && err;
endmodule

// File: rtl/stmem_ctrl_chk.sv
module stmem_ctrl_chk #(
  parameter int NUM_CS     = 2,
  parameter int STROBE_CYC = 2,
  parameter int TMO_CYC    = 255
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CS-1:0] cfg_bus16_i,
  input logic              cfg_exact_rd_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [NUM_CS-1:0] mem_cs_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic              mem_pwe_no,
  input logic [3:0]        mem_bs_no,
  input logic [1:0]        addr_lo_i,
  input logic              mem_dq_oe_o
);
  localparam int LIM = STROBE_CYC + TMO_CYC + 2;
  localparam int SCW = $clog2(LIM + 2) + 1;

  logic           strobe_any, bus16;
  logic [SCW-1:0] slen_q;

  assign strobe_any = !mem_oe_no || !mem_we_no || !mem_pwe_no;
  assign bus16      = |(~mem_cs_no & cfg_bus16_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         slen_q <= '0;
    else if (!strobe_any) slen_q <= '0;
    else if (slen_q != {SCW{1'b1}}) slen_q <= slen_q + 1'b1;

  p_idle_no_cs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (&mem_cs_no));
  p_cs_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));
  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~mem_oe_no, ~mem_we_no, ~mem_pwe_no}) <= 1);
  p_rd_float_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);
  p_wr_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no || !mem_pwe_no) |-> mem_dq_oe_o);
  p_strobe_in_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_any |-> ($countones(~mem_cs_no) == 1));
  p_setup_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_any) |-> $past(!(&mem_cs_no)));
  p_dflt_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no && !cfg_exact_rd_i) |->
      (bus16 ? (mem_bs_no == 4'b1100 && !addr_lo_i[0])
             : (mem_bs_no == 4'b0000 && addr_lo_i == 2'b00)));
  p_tmo_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slen_q <= SCW'(LIM));
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind stmem_ctrl stmem_ctrl_chk #(
  .NUM_CS     (NUM_CS),
  .STROBE_CYC (STROBE_CYC),
  .TMO_CYC    (TMO_CYC)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_bus16_i    (cfg_bus16_i),
  .cfg_exact_rd_i (cfg_exact_rd_i),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .mem_cs_no      (mem_cs_no),
  .mem_oe_no      (mem_oe_no),
  .mem_we_no      (mem_we_no),
  .mem_pwe_no     (mem_pwe_no),
  .mem_bs_no      (mem_bs_no),
  .addr_lo_i      (mem_addr_o[1:0]),
  .mem_dq_oe_o    (mem_dq_oe_o)
);

// File: tb/stmem_ctrl_test.sv
module stmem_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS = 2, AW = 16, CS_LSB = 12;
  localparam int SETUP_CYC = 1, STROBE_CYC = 2, HOLD_CYC = 1, TMO_CYC = 255;
  localparam int NEVER = 100000;

  typedef struct packed {
    logic [1:0]  kind;   // 0 read, 1 we, 2 pwe
    logic [15:0] addr;
    logic [3:0]  bs;
    logic [31:0] dq;
  } bus_item_t;
  typedef struct packed {
    logic [31:0] rdata;
    logic        err;
    logic        cmp_data;
  } rsp_item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NUM_CS-1:0] cfg_bus16 = 2'b10, cfg_var = 2'b00;
  logic cfg_exact = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'd2;
  logic [3:0] req_be = 4'h0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NUM_CS-1:0] cs_n;
  logic oe_n, we_n, pwe_n, dq_oe, rdy = 1'b0;
  logic [3:0] bs_n;
  logic [AW-1:0] maddr;
  logic [31:0] dq_out, dq_in;

  int n_chk = 0, n_err = 0;
  int rdy_n = NEVER;
  int len_lo = STROBE_CYC, len_hi = STROBE_CYC;
  bus_item_t bus_q[$];
  string     bus_tag_q[$];
  rsp_item_t rsp_q[$];
  string     rsp_tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] dev_word(input logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction
  assign dq_in = dev_word(maddr);

  stmem_ctrl #(
    .NUM_CS(NUM_CS), .AW(AW), .CS_LSB(CS_LSB), .SETUP_CYC(SETUP_CYC),
    .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC), .TMO_CYC(TMO_CYC), .SYNC_STAGES(2)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_bus16_i(cfg_bus16), .cfg_var_i(cfg_var),
    .cfg_exact_rd_i(cfg_exact), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_size_i(req_size), .req_be_i(req_be),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err), .mem_cs_no(cs_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_pwe_no(pwe_n), .mem_bs_no(bs_n), .mem_addr_o(maddr), .mem_dq_o(dq_out),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in), .mem_rdy_i(rdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: bus scoreboard, phase timing, device ready model
  logic prev_s = 1'b0, prev_c = 1'b0, first = 1'b0, had = 1'b0;
  int pre = 0, hold = 0, slen = 0, scnt = 0;
  always @(negedge clk) begin
    logic s, c;
    bus_item_t bi;
    rsp_item_t ri;
    string t;
    logic [1:0] kind;
    s = !oe_n || !we_n || !pwe_n;
    c = !(&cs_n);
    if (!rst_n) begin
      prev_s = 0; prev_c = 0; first = 0; had = 0; scnt = 0; rdy = 0;
    end else begin
      if (s) scnt++; else scnt = 0;
      rdy = s && (scnt >= rdy_n);
      if (c && !prev_c) begin pre = 0; hold = 0; first = 1; had = 0; end
      if (s && !prev_s) begin
        if (first) chk("R5 setup cycles", pre, SETUP_CYC);
        first = 0; had = 1; hold = 0; slen = 1;
        kind = !oe_n ? 2'd0 : (!we_n ? 2'd1 : 2'd2);
        if (bus_q.size() == 0) chk("R9 unexpected strobe", 1, 0);
        else begin
          bi = bus_q.pop_front();
          t = bus_tag_q.pop_front();
          chk({t, " strobe kind"}, kind, bi.kind);
          chk({t, " addr"}, maddr, bi.addr);
          chk({t, " byte selects"}, bs_n, bi.bs);
          chk({t, " dq drive"}, dq_oe, bi.kind != 2'd0);
          if (bi.kind != 2'd0) chk({t, " write data"}, dq_out, bi.dq);
        end
      end else if (s) slen++;
      if (!s && prev_s) begin
        n_chk++;
        if (slen < len_lo || slen > len_hi) begin
          n_err++;
          $display("FAIL R6 strobe length act=%0d exp=%0d..%0d", slen, len_lo, len_hi);
        end
      end
      if (c && !s) begin if (first) pre++; else hold++; end
      if (!c && prev_c && had) chk("R5 hold cycles", hold, HOLD_CYC);
      if (rsp_valid) begin
        if (rsp_q.size() == 0) chk("R12 unexpected response", 1, 0);
        else begin
          ri = rsp_q.pop_front();
          t = rsp_tag_q.pop_front();
          chk({t, " R12 err"}, rsp_err, ri.err);
          if (ri.cmp_data) chk({t, " R12 rdata"}, rsp_rdata, ri.rdata);
          chk({t, " R9 all strobes issued"}, bus_q.size(), 0);
        end
      end
      prev_s = s; prev_c = c;
    end
  end

  task automatic push_acc(input logic [1:0] k, input logic [15:0] a, input logic [3:0] b,
                          input logic [31:0] d, input string tag);
    bus_item_t bi;
    bi.kind = k; bi.addr = a; bi.bs = b; bi.dq = d;
    bus_q.push_back(bi);
    bus_tag_q.push_back(tag);
  endtask

  task automatic do_req(input logic we, input logic [15:0] addr, input logic [1:0] size,
                        input logic [3:0] be, input logic [31:0] wd, input int rn,
                        input string tag);
    logic cs, b16, vd, tmo;
    logic [1:0] k;
    logic [15:0] a;
    logic [3:0] bs;
    logic [31:0] rd;
    int n;
    rsp_item_t ri;
    cs  = addr[CS_LSB];
    b16 = cfg_bus16[cs];
    vd  = cfg_var[cs];
    tmo = vd && (rn > 1000);
    k   = !we ? 2'd0 : (vd ? 2'd2 : 2'd1);
    rd  = '0;
    if (!b16) begin
      a = {addr[15:2], 2'b00}; bs = 4'b0000;
      if (we) bs = ~be;
      else if (cfg_exact && size == 2'd1) begin
        a = {addr[15:2], addr[1], 1'b0}; bs = addr[1] ? 4'b0011 : 4'b1100;
      end else if (cfg_exact && size == 2'd0) begin
        a = addr; bs = ~(4'b0001 << addr[1:0]);
      end
      push_acc(k, a, bs, wd, tag);
      if (!we) rd = dev_word(a);
    end else begin
      n = we ? ((size == 2'd2) ? 2 : 1) : ((!cfg_exact || size == 2'd2) ? 2 : 1);
      if (tmo) n = 1;
      for (int j = 0; j < n; j++) begin
        logic h;
        h  = (n == 2 || (tmo && (we ? size == 2'd2 : (!cfg_exact || size == 2'd2))))
             ? j[0] : addr[1];
        a  = {addr[15:2], h, 1'b0};
        bs = 4'b1100;
        if (we) bs = {2'b11, ~(h ? be[3:2] : be[1:0])};
        else if (cfg_exact && size == 2'd0) begin
          a[0] = addr[0]; bs = {2'b11, addr[0] ? 2'b01 : 2'b10};
        end
        push_acc(k, a, bs, {16'h0000, h ? wd[31:16] : wd[15:0]}, tag);
        if (!we) begin
          if (h) rd[31:16] = a; else rd[15:0] = a;
        end
      end
    end
    ri.rdata = rd; ri.err = tmo; ri.cmp_data = !tmo;
    rsp_q.push_back(ri);
    rsp_tag_q.push_back(tag);
    rdy_n = rn;
    if (tmo)      begin len_lo = TMO_CYC; len_hi = STROBE_CYC + TMO_CYC + 3; end
    else if (vd)  begin len_lo = (rn > STROBE_CYC) ? rn : STROBE_CYC; len_hi = rn + STROBE_CYC + 3; end
    else          begin len_lo = STROBE_CYC; len_hi = STROBE_CYC; end
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = addr; req_size = size;
    req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (rsp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (NEVER) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs idle", cs_n, 2'b11);
    chk("R1 strobes idle", {oe_n, we_n, pwe_n}, 3'b111);
    chk("R1 byte selects idle", bs_n, 4'hF);
    chk("R1 bus not driven", dq_oe, 0);
    chk("R1 no response", rsp_valid, 0);
    chk("R1 ready", req_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // 32-bit path, fixed-timing device
    do_req(1, 16'h0000, 2'd2, 4'hF, 32'h1122_3344, NEVER, "R2 R4 word write cs0 addr 0");
    do_req(1, 16'h0010, 2'd2, 4'b0110, 32'hDEAD_BEEF, NEVER, "R10 partial write");
    do_req(0, 16'h0013, 2'd0, 4'h0, 32'h0, NEVER, "R7 default byte read");
    do_req(0, 16'h0010, 2'd2, 4'h0, 32'h0, NEVER, "R3 word read");
    cfg_exact = 1;
    do_req(0, 16'h0013, 2'd0, 4'h0, 32'h0, NEVER, "R8 exact byte read");
    do_req(0, 16'h0016, 2'd1, 4'h0, 32'h0, NEVER, "R8 exact half read");
    do_req(0, 16'h0018, 2'd2, 4'h0, 32'h0, NEVER, "R8 exact word read");
    cfg_exact = 0;

    // 16-bit path on chip select 1
    do_req(1, 16'h1020, 2'd2, 4'b1101, 32'hCAFE_F00D, NEVER, "R9 R10 split word write");
    do_req(1, 16'h1022, 2'd1, 4'b1100, 32'hABCD_0000, NEVER, "R10 upper half write");
    do_req(0, 16'h1025, 2'd0, 4'h0, 32'h0, NEVER, "R7 R9 default byte read 16b");
    do_req(0, 16'h1028, 2'd2, 4'h0, 32'h0, NEVER, "R9 word read 16b");
    cfg_exact = 1;
    do_req(0, 16'h1025, 2'd0, 4'h0, 32'h0, NEVER, "R8 exact odd byte 16b");
    do_req(0, 16'h1027, 2'd0, 4'h0, 32'h0, NEVER, "R8 exact upper odd byte 16b");
    do_req(0, 16'h1026, 2'd1, 4'h0, 32'h0, NEVER, "R8 R9 exact upper half 16b");
    do_req(0, 16'h102C, 2'd2, 4'h0, 32'h0, NEVER, "R8 R9 exact word 16b");
    cfg_exact = 0;

    // variable-latency devices
    cfg_var = 2'b11;
    do_req(1, 16'h0020, 2'd2, 4'hF, 32'h0BAD_CAFE, 0, "R4 pwe write");
    do_req(0, 16'h0024, 2'd2, 4'h0, 32'h0, 6, "R6 ready stretch 6");
    do_req(0, 16'h0028, 2'd2, 4'h0, 32'h0, 0, "R6 ready early");
    do_req(0, 16'h1030, 2'd2, 4'h0, 32'h0, 9, "R6 R9 stretch 16b");
    do_req(0, 16'h0030, 2'd2, 4'h0, 32'h0, NEVER, "R11 timeout 32b");
    do_req(0, 16'h1034, 2'd2, 4'h0, 32'h0, NEVER, "R11 timeout no second half");
    do_req(0, 16'h0034, 2'd2, 4'h0, 32'h0, 3, "R11 recovery read");

    // fixed device ignores ready
    cfg_var = 2'b00;
    do_req(0, 16'h0038, 2'd2, 4'h0, 32'h0, NEVER, "R6 fixed device ignores ready");
    do_req(1, 16'h003C, 2'd2, 4'hF, 32'h5555_AAAA, NEVER, "R4 we write after var mode");

    repeat (4) @(negedge clk);
    chk("R12 no pending strobes", bus_q.size(), 0);
    chk("R12 no pending responses", rsp_q.size(), 0);
    finish_run();
  end
endmodule